// File: doc/BRIEF.md
# Unified Data Address Space Decoder

This block sits beside the load/store path of a small 8-bit processor core and tells the rest of the datapath which storage a data-space address lands in. A data-space address is classified into one of four targets: the 32-entry working register file, the 64 core I/O registers, the extended I/O registers, or RAM. The result comes with the offset of the address inside the selected target and a flag saying whether that target supports single-bit set, clear and test operations. Addresses above the configured RAM top select nothing and raise an out-of-range flag.

A second, narrow port carries a 6-bit I/O-space address. It is translated onto the same core I/O registers, so every core I/O register has two names: its I/O number on the narrow port, and that number plus 0x20 on the data port. When both ports hit the same core I/O register in one cycle, the data port keeps its access and the narrow port is told to retry. Both results are registered and appear one clock after the request. The extended I/O window starts at 0x60 and ends at the `EXT_TOP` parameter, and RAM occupies `EXT_TOP+1` up to `RAM_TOP`.

Top module: `data_space_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, every output is 0 (`data_region` 0 means no region).
- R2: A valid data address in 0x00 to 0x1F gives `data_region` = 1 (register file), `data_offset` equal to the address, `data_bit_ok` = 1 and `data_oor` = 0.
- R3: A valid data address in 0x20 to 0x5F gives `data_region` = 2 (core I/O), `data_offset` = address minus 0x20, and `data_bit_ok` = 1 only when that offset is below 0x20.
- R4: A valid data address from 0x60 to `EXT_TOP` gives `data_region` = 3 (extended I/O), `data_offset` = address minus 0x60 and `data_bit_ok` = 0.
- R5: A valid data address from `EXT_TOP+1` to `RAM_TOP` gives `data_region` = 4 (RAM), `data_offset` = address minus (`EXT_TOP+1`) and `data_bit_ok` = 0.
- R6: A valid data address above `RAM_TOP` gives `data_region` = 0, `data_offset` = 0, `data_bit_ok` = 0 and `data_oor` = 1.
- R7: A valid I/O-port request with no clash gives `io_hit` = 1, `io_busy` = 0, `io_offset` equal to the 6-bit I/O address, and `io_bit_ok` = 1 exactly when that address is below 0x20; an extended I/O register can never be named through this port.
- R8: When the data port is valid and selects core I/O at the same offset as a valid I/O-port request, the data result is unchanged, `io_hit` = 0 and `io_busy` = 1.
- R9: Every result appears on the clock edge after the request; with a port's valid low, that port's outputs are all 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_valid | input | 1 | Data-space request present |
| data_addr | input | ADDR_W | Data-space address |
| io_valid | input | 1 | I/O-space request present |
| io_addr | input | 6 | I/O-space register number |
| data_region | output | 3 | 0 none, 1 register file, 2 core I/O, 3 extended I/O, 4 RAM |
| data_offset | output | ADDR_W | Offset inside the selected region |
| data_bit_ok | output | 1 | Target supports single-bit operations |
| data_oor | output | 1 | Data address above the RAM top |
| io_hit | output | 1 | I/O request granted to a core I/O register |
| io_busy | output | 1 | I/O request lost to the data port |
| io_offset | output | 6 | Core I/O register index for the I/O request |
| io_bit_ok | output | 1 | I/O register supports single-bit operations |

## Verification
The bench builds the decoder with a 12-bit data address, the extended window ending at 0x0FF and RAM ending at 0x4FF. With these values a uniform random address falls into every one of the five outcomes, including out-of-range in most draws, and the limits `EXT_TOP`, `EXT_TOP+1`, `RAM_TOP` and `RAM_TOP+1` sit within the directed cases. Random I/O numbers are paired with data addresses forced into the core I/O window often enough that the same-register clash is exercised repeatedly alongside near misses one register apart.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [2:0] {
        RGN_NONE = 3'd0,
        RGN_GPR  = 3'd1,
        RGN_CIO  = 3'd2,
        RGN_XIO  = 3'd3,
        RGN_RAM  = 3'd4
    } region_e;

    localparam int IO_AW      = 6;
    localparam int GPR_COUNT  = 32;
    localparam int CIO_BASE   = GPR_COUNT;
    localparam int CIO_COUNT  = 1 << IO_AW;
    localparam int XIO_BASE   = CIO_BASE + CIO_COUNT;
    localparam int BIT_LIMIT  = 32;

endpackage

// File: rtl/dsd_data_decode.sv
module dsd_data_decode
    import dsd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int EXT_TOP = 'h0FF,
    parameter int RAM_TOP = 'h08FF
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ADDR_W-1:0] offset,
    output logic              bit_ok,
    output logic              oor
);
    localparam int RAM_BASE = EXT_TOP + 1;

    logic [31:0] a_w;

    always_comb begin
        a_w    = 32'(addr);
        region = RGN_NONE;
        offset = '0;
        bit_ok = 1'b0;
        oor    = 1'b0;
        if (valid) begin
            if (a_w < 32'(CIO_BASE)) begin
                region = RGN_GPR;
                offset = addr;
                bit_ok = 1'b1;
            end else if (a_w < 32'(XIO_BASE)) begin
                region = RGN_CIO;
                offset = ADDR_W'(a_w - 32'(CIO_BASE));
                bit_ok = (a_w - 32'(CIO_BASE)) < 32'(BIT_LIMIT);
            end else if (a_w <= 32'(EXT_TOP)) begin
                region = RGN_XIO;
                offset = ADDR_W'(a_w - 32'(XIO_BASE));
            end else if (a_w <= 32'(RAM_TOP)) begin
                region = RGN_RAM;
                offset = ADDR_W'(a_w - 32'(RAM_BASE));
            end else begin
                oor = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsd_io_map.sv
module dsd_io_map
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              io_valid,
    input  logic [IO_AW-1:0]  io_addr,
    input  region_e           d_region,
    input  logic [ADDR_W-1:0] d_offset,
    output logic              hit,
    output logic              busy,
    output logic [IO_AW-1:0]  offset,
    output logic              bit_ok
);
    logic clash;

    always_comb begin
        clash  = io_valid && (d_region == RGN_CIO) && (d_offset == ADDR_W'(io_addr));
        hit    = io_valid && !clash;
        busy   = clash;
        offset = io_valid ? io_addr : '0;
        bit_ok = io_valid && (32'(io_addr) < 32'(BIT_LIMIT));
    end

endmodule

// File: rtl/data_space_decoder.sv
module data_space_decoder
    import dsd_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int EXT_TOP = 'h0FF,
    parameter int RAM_TOP = 'h08FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_valid,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic              io_valid,
    input  logic [5:0]        io_addr,
    output logic [2:0]        data_region,
    output logic [ADDR_W-1:0] data_offset,
    output logic              data_bit_ok,
    output logic              data_oor,
    output logic              io_hit,
    output logic              io_busy,
    output logic [5:0]        io_offset,
    output logic              io_bit_ok
);
    localparam int XIO_SPAN = EXT_TOP - XIO_BASE;

    generate
        if (ADDR_W < 7 || EXT_TOP < XIO_BASE || RAM_TOP <= EXT_TOP
            || RAM_TOP >= (1 << ADDR_W) + 1) begin : g_bad_cfg
            $error("data_space_decoder: inconsistent window parameters");
        end
    endgenerate

    typedef struct packed {
        region_e           region;
        logic [ADDR_W-1:0] d_off;
        logic              d_bit;
        logic              d_oor;
        logic              io_hit;
        logic              io_busy;
        logic [IO_AW-1:0]  io_off;
        logic              io_bit;
    } state_t;

    state_t st_d, st_q;

    region_e           dec_region;
    logic [ADDR_W-1:0] dec_offset;
    logic              dec_bit, dec_oor;
    logic              map_hit, map_busy, map_bit;
    logic [IO_AW-1:0]  map_off;

    dsd_data_decode #(
        .ADDR_W (ADDR_W),
        .EXT_TOP(EXT_TOP),
        .RAM_TOP(RAM_TOP)
    ) u_decode (
        .valid (data_valid),
        .addr  (data_addr),
        .region(dec_region),
        .offset(dec_offset),
        .bit_ok(dec_bit),
        .oor   (dec_oor)
    );

    dsd_io_map #(
        .ADDR_W(ADDR_W)
    ) u_iomap (
        .io_valid(io_valid),
        .io_addr (io_addr),
        .d_region(dec_region),
        .d_offset(dec_offset),
        .hit     (map_hit),
        .busy    (map_busy),
        .offset  (map_off),
        .bit_ok  (map_bit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.region  = dec_region;
        st_d.d_off   = dec_offset;
        st_d.d_bit   = dec_bit;
        st_d.d_oor   = dec_oor;
        st_d.io_hit  = map_hit;
        st_d.io_busy = map_busy;
        st_d.io_off  = map_off;
        st_d.io_bit  = map_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_region = st_q.region;
    assign data_offset = st_q.d_off;
    assign data_bit_ok = st_q.d_bit;
    assign data_oor    = st_q.d_oor;
    assign io_hit      = st_q.io_hit;
    assign io_busy     = st_q.io_busy;
    assign io_offset   = st_q.io_off;
    assign io_bit_ok   = st_q.io_bit;

    // R6: an out-of-range flag never comes with a selected region
    p_oor_no_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_oor |-> (data_region == 3'd0 && !data_bit_ok));

    // R4: extended window offsets stay inside the configured span
    p_xio_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_region == 3'd3) |-> (32'(data_offset) <= 32'(XIO_SPAN) && !data_bit_ok));

    // R3: bit access on core I/O only in the lower half
    p_cio_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_region == 3'd2 && data_bit_ok) |-> (32'(data_offset) < 32'(BIT_LIMIT)));

    // R7: granted I/O request carries bit capability only below 0x20
    p_io_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        io_bit_ok |-> (io_offset < 6'd32));

    // R8: a clash loses the I/O grant and leaves data on core I/O at the same index
    p_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        io_busy |-> (!io_hit && data_region == 3'd2 && data_offset == ADDR_W'(io_offset)));

    // R9: an idle data port yields no region on the next cycle
    p_idle_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |=> (data_region == 3'd0 && !data_oor));

    // R9: an idle I/O port yields no grant and no clash
    p_idle_io_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid |=> (!io_hit && !io_busy));

endmodule

// File: tb/tb_data_space_decoder.sv
module tb_data_space_decoder;

    localparam int AW      = 12;
    localparam int EXT_TOP = 'h0FF;
    localparam int RAM_TOP = 'h4FF;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          data_valid;
    logic [AW-1:0] data_addr;
    logic          io_valid;
    logic [5:0]    io_addr;
    logic [2:0]    data_region;
    logic [AW-1:0] data_offset;
    logic          data_bit_ok, data_oor;
    logic          io_hit, io_busy, io_bit_ok;
    logic [5:0]    io_offset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    data_space_decoder #(
        .ADDR_W (AW),
        .EXT_TOP(EXT_TOP),
        .RAM_TOP(RAM_TOP)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .data_valid(data_valid), .data_addr(data_addr),
        .io_valid(io_valid), .io_addr(io_addr),
        .data_region(data_region), .data_offset(data_offset),
        .data_bit_ok(data_bit_ok), .data_oor(data_oor),
        .io_hit(io_hit), .io_busy(io_busy),
        .io_offset(io_offset), .io_bit_ok(io_bit_ok)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // expected data-side result and the requirement it follows from
    function automatic void exp_data(input bit v, input int a, output int rg, output int off,
                                     output int b, output int o, output string req);
        rg = 0; off = 0; b = 0; o = 0; req = "R9";
        if (v) begin
            if (a < 'h20)            begin rg = 1; off = a;             b = 1; req = "R2"; end
            else if (a < 'h60)       begin rg = 2; off = a - 'h20;      b = (off < 'h20); req = "R3"; end
            else if (a <= EXT_TOP)   begin rg = 3; off = a - 'h60;      req = "R4"; end
            else if (a <= RAM_TOP)   begin rg = 4; off = a - EXT_TOP - 1; req = "R5"; end
            else                     begin o = 1; req = "R6"; end
        end
    endfunction

    task automatic step(bit dv, int a, bit iv, int ia);
        int rg, off, b, o, h, bz, ioff, ib;
        string rq, iq;
        @(negedge clk);
        data_valid = dv; data_addr = AW'(a); io_valid = iv; io_addr = 6'(ia);
        exp_data(dv, a, rg, off, b, o, rq);
        iq = "R9"; h = 0; bz = 0; ioff = 0; ib = 0;
        if (iv) begin
            ioff = ia; ib = (ia < 'h20);
            if (rg == 2 && off == ia) begin bz = 1; iq = "R8"; end
            else begin h = 1; iq = "R7"; end
        end
        @(posedge clk);
        #2;
        chk(rq, "data_region", data_region, rg);
        chk(rq, "data_offset", data_offset, off);
        chk(rq, "data_bit_ok", data_bit_ok, b);
        chk(rq, "data_oor",    data_oor, o);
        chk(iq, "io_hit",      io_hit, h);
        chk(iq, "io_busy",     io_busy, bz);
        chk(iq, "io_offset",   io_offset, ioff);
        chk(iq, "io_bit_ok",   io_bit_ok, ib);
    endtask

    initial begin
        rst_n = 1'b0; data_valid = 1'b1; data_addr = AW'('h25);
        io_valid = 1'b1; io_addr = 6'h05;
        repeat (3) @(posedge clk);
        #2;
        // R1: reset holds every output at zero despite active requests
        chk("R1", "data_region", data_region, 0);
        chk("R1", "data_offset", data_offset, 0);
        chk("R1", "data_oor",    data_oor, 0);
        chk("R1", "io_hit",      io_hit, 0);
        chk("R1", "io_offset",   io_offset, 0);
        @(negedge clk);
        data_valid = 1'b0; io_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        chk("R1", "data_region after release", data_region, 0);
        chk("R1", "io_busy after release",     io_busy, 0);

        // directed boundaries: R2 R3 R4 R5 R6
        step(1, 'h000, 0, 0);
        step(1, 'h01F, 0, 0);
        step(1, 'h020, 0, 0);
        step(1, 'h03F, 0, 0);
        step(1, 'h040, 0, 0);
        step(1, 'h05F, 0, 0);
        step(1, 'h060, 0, 0);
        step(1, EXT_TOP, 0, 0);
        step(1, EXT_TOP + 1, 0, 0);
        step(1, RAM_TOP, 0, 0);
        step(1, RAM_TOP + 1, 0, 0);
        step(1, 'hFFF, 0, 0);
        // R7: both halves of the I/O space
        step(0, 0, 1, 'h00);
        step(0, 0, 1, 'h1F);
        step(0, 0, 1, 'h20);
        step(0, 0, 1, 'h3F);
        // R8: same register through both names, and near misses
        step(1, 'h020, 1, 'h00);
        step(1, 'h05F, 1, 'h3F);
        step(1, 'h030, 1, 'h11);
        step(1, 'h010, 1, 'h10);
        step(1, 'h070, 1, 'h10);
        // R9: idle ports
        step(0, 'h025, 0, 'h05);

        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++) begin
            bit dv = ($urandom_range(3) != 0);
            bit iv = ($urandom_range(2) != 0);
            int ia = $urandom_range(63);
            int a  = $urandom_range(4095);
            int mode = $urandom_range(3);
            if (mode == 0) a = 'h20 + ia;
            else if (mode == 1) a = $urandom_range('h5F);
            step(dv, a, iv, ia);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule